// File: doc/BRIEF.md
# Over-Drive Mode Switching Controller

This block steers the core voltage regulator between its normal operating mode and a boosted over-drive mode. Software writes a two-bit configuration word: an enable bit that asks the regulator to get ready for over-drive, and a switch bit that actually moves it there. Each step is a level request/acknowledge handshake with the regulator. Two read-only flags report when each step has been acknowledged. While the regulator changes mode in either direction, the block holds a stall output high so the system clock can be frozen.

Leaving over-drive works in two legal orders. Software can clear both bits in one write, which returns to normal and then drops the preparation. It can also clear the switch bit first, which returns to normal and keeps over-drive prepared, and clear the enable bit later. Stop-mode entry, or a regulator that is bypassed, cancels over-drive at once. A counter flags any handshake that waits longer than a configurable limit.

Top module: `odrive_ctrl`

## Requirements
- R1: After reset, every output is 0: both bits, both ready flags, both requests, the stall and the timeout flag.
- R2: A write with the enable bit set is accepted only when over-drive is fully off, bypass is low, stop entry is low and the scale input is 2'b01 (scale 1) or 2'b10 (scale 2). When it is accepted, the enable bit and the preparation request go high after the next clock edge. Otherwise the write changes nothing.
- R3: The enable-ready flag rises on the edge after the preparation acknowledge is sampled high, and the preparation request stays high for as long as over-drive is enabled.
- R4: A write with the switch bit set while enable-ready is low is ignored, and the switch bit reads back as 0.
- R5: A write of enable=1 and switch=1 while enabled and ready raises the switch bit, the switch request and the stall. When the switch acknowledge is sampled high, the switch-ready flag rises and the stall falls in the same cycle.
- R6: A write of enable=1 and switch=0 while over-drive is active drops the switch request and raises the stall, and switch-ready stays high. When the switch acknowledge is sampled low, switch-ready and the stall fall together, while the enable bit and enable-ready stay high.
- R7: A write of enable=0 and switch=0 while over-drive is active clears both bits at once and performs the same return to normal. The preparation request then drops and the block goes back to the fully off state.
- R8: A write of enable=0 while enabled, ready and not switched clears the enable bit, the preparation request and enable-ready after the next edge. A new enable is accepted once the preparation acknowledge has fallen.
- R9: Writes that arrive while any handshake is in progress have no effect.
- R10: Stop entry or regulator bypass, while over-drive is in any state other than off, clears both bits, both ready flags, both requests and the stall after the next edge. Enable writes stay ignored until both acknowledges are low.
- R11: If a handshake waits ACK_TIMEOUT cycles without its acknowledge, the timeout flag sets. It stays set until the next configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgEn | input | 1 | Written value of the enable bit |
| cfgSw | input | 1 | Written value of the switch bit |
| voltScale | input | 2 | Active voltage scale: 01 scale 1, 10 scale 2, 11 scale 3 |
| regBypass | input | 1 | Regulator is bypassed |
| stopEntry | input | 1 | Stop-mode entry request |
| prepAck | input | 1 | Regulator acknowledge of preparation |
| switchAck | input | 1 | Regulator acknowledge of mode switch |
| enBit | output | 1 | Read-back of the enable bit |
| swBit | output | 1 | Read-back of the switch bit |
| enRdy | output | 1 | Preparation acknowledged (read-only) |
| swRdy | output | 1 | Over-drive switch complete (read-only) |
| prepReq | output | 1 | Preparation request to the regulator |
| switchReq | output | 1 | Switch request to the regulator |
| sysStall | output | 1 | Stall the system clock during a switch |
| timeoutErr | output | 1 | Acknowledge did not arrive in time |

## Verification
The properties assume the regulator answers as a level follower: each acknowledge copies its request after some delay, and it never rises unless its request is high. The stimulus model in the bench is a delay line of a few cycles on each request, which can be frozen to provoke the timeout. Stop entry and bypass are driven only in cycles with no write, or with writes the properties expect to be dropped. The scale input changes only while over-drive is off.

// File: rtl/odc_pkg.sv
package odc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_READY,
    ST_TO_OD,
    ST_ACTIVE,
    ST_TO_NORM,
    ST_UNPREP,
    ST_DRAIN
  } odState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setSw;
    logic clrSw;
    logic waitOn;
    logic cntClr;
    logic errClr;
  } odStrobe_t;

endpackage

// File: rtl/odc_ctrl.sv
module odc_ctrl
  import odc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic       cfgEn,
  input  logic       cfgSw,
  input  logic [1:0] voltScale,
  input  logic       regBypass,
  input  logic       stopEntry,
  input  logic       prepAck,
  input  logic       switchAck,
  input  logic       enBitQ,
  output odStrobe_t  stb,
  output logic       prepReq,
  output logic       switchReq,
  output logic       sysStall,
  output logic       enRdy,
  output logic       swRdy
);

  odState_t stQ, stNxt;
  logic     abortReq;
  logic     scaleOk;

  assign abortReq = stopEntry | regBypass;
  assign scaleOk  = (voltScale == 2'b01) || (voltScale == 2'b10);

  always_comb begin
    stNxt = stQ;
    stb   = '0;
    unique case (stQ)
      ST_IDLE: begin
        if (!abortReq && cfgWr && cfgEn && scaleOk) begin
          stNxt     = ST_PREP;
          stb.setEn = 1'b1;
        end
      end
      ST_PREP: begin
        if (prepAck) stNxt = ST_READY;
      end
      ST_READY: begin
        if (cfgWr) begin
          if (!cfgEn) begin
            stNxt     = ST_UNPREP;
            stb.clrEn = 1'b1;
          end else if (cfgSw) begin
            stNxt     = ST_TO_OD;
            stb.setSw = 1'b1;
          end
        end
      end
      ST_TO_OD: begin
        if (switchAck) stNxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (cfgWr && !cfgSw) begin
          stNxt     = ST_TO_NORM;
          stb.clrSw = 1'b1;
          stb.clrEn = !cfgEn;
        end
      end
      ST_TO_NORM: begin
        if (!switchAck) stNxt = enBitQ ? ST_READY : ST_UNPREP;
      end
      ST_UNPREP: begin
        if (!prepAck) stNxt = ST_IDLE;
      end
      ST_DRAIN: begin
        if (!prepAck && !switchAck) stNxt = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase

    // Stop entry or bypass cancels any over-drive activity
    if (abortReq && (stQ != ST_IDLE) && (stQ != ST_DRAIN)) begin
      stNxt     = ST_DRAIN;
      stb.setEn = 1'b0;
      stb.setSw = 1'b0;
      stb.clrEn = 1'b1;
      stb.clrSw = 1'b1;
    end

    stb.waitOn = (stQ inside {ST_PREP, ST_TO_OD, ST_TO_NORM, ST_UNPREP, ST_DRAIN});
    stb.cntClr = (stNxt != stQ);
    stb.errClr = cfgWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNxt;
  end

  assign prepReq   = (stQ inside {ST_PREP, ST_READY, ST_TO_OD, ST_ACTIVE, ST_TO_NORM});
  assign switchReq = (stQ inside {ST_TO_OD, ST_ACTIVE});
  assign sysStall  = (stQ inside {ST_TO_OD, ST_TO_NORM});
  assign enRdy     = (stQ inside {ST_READY, ST_TO_OD, ST_ACTIVE, ST_TO_NORM});
  assign swRdy     = (stQ inside {ST_ACTIVE, ST_TO_NORM});

endmodule

// File: rtl/odc_dpath.sv
module odc_dpath
  import odc_pkg::*;
#(
  parameter int ACK_TIMEOUT = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  odStrobe_t stb,
  output logic      enBit,
  output logic      swBit,
  output logic      timeoutErr
);

  localparam int CW = $clog2(ACK_TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(ACK_TIMEOUT);
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_TIMEOUT - 1);

  logic [CW-1:0] waitCnt;
  logic          tmoHit;

  assign tmoHit = stb.waitOn && !stb.cntClr && (waitCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit <= 1'b0;
      swBit <= 1'b0;
    end else begin
      if (stb.clrEn)      enBit <= 1'b0;
      else if (stb.setEn) enBit <= 1'b1;
      if (stb.clrSw)      swBit <= 1'b0;
      else if (stb.setSw) swBit <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               waitCnt <= '0;
    else if (stb.cntClr)                     waitCnt <= '0;
    else if (stb.waitOn && waitCnt != CNT_MAX) waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           timeoutErr <= 1'b0;
    else if (tmoHit)     timeoutErr <= 1'b1;
    else if (stb.errClr) timeoutErr <= 1'b0;
  end

endmodule

// File: rtl/odrive_ctrl.sv
module odrive_ctrl
  import odc_pkg::*;
#(
  parameter int ACK_TIMEOUT = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic       cfgEn,
  input  logic       cfgSw,
  input  logic [1:0] voltScale,
  input  logic       regBypass,
  input  logic       stopEntry,
  input  logic       prepAck,
  input  logic       switchAck,
  output logic       enBit,
  output logic       swBit,
  output logic       enRdy,
  output logic       swRdy,
  output logic       prepReq,
  output logic       switchReq,
  output logic       sysStall,
  output logic       timeoutErr
);

  odStrobe_t stb;

  odc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgEn     (cfgEn),
    .cfgSw     (cfgSw),
    .voltScale (voltScale),
    .regBypass (regBypass),
    .stopEntry (stopEntry),
    .prepAck   (prepAck),
    .switchAck (switchAck),
    .enBitQ    (enBit),
    .stb       (stb),
    .prepReq   (prepReq),
    .switchReq (switchReq),
    .sysStall  (sysStall),
    .enRdy     (enRdy),
    .swRdy     (swRdy)
  );

  odc_dpath #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .enBit      (enBit),
    .swBit      (swBit),
    .timeoutErr (timeoutErr)
  );

endmodule

// File: rtl/odc_checks.sv
module odc_checks (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWr,
  input logic       cfgEn,
  input logic       cfgSw,
  input logic [1:0] voltScale,
  input logic       regBypass,
  input logic       stopEntry,
  input logic       enBit,
  input logic       swBit,
  input logic       enRdy,
  input logic       swRdy,
  input logic       prepReq,
  input logic       switchReq,
  input logic       sysStall
);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgEn && !enBit && !(voltScale == 2'b01 || voltScale == 2'b10)) |=> !enBit);

  p_sw_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgSw && !enRdy) |=> !swBit);

  p_stall_prepared_r5: assert property (@(posedge clk) disable iff (!rstN)
    sysStall |-> (enRdy && prepReq));

  p_swrdy_prepared_r6: assert property (@(posedge clk) disable iff (!rstN)
    swRdy |-> enRdy);

  p_return_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swRdy) |-> !sysStall);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stopEntry || regBypass) |=>
      (!prepReq && !switchReq && !sysStall && !enBit && !swBit && !enRdy && !swRdy));

endmodule

bind odrive_ctrl odc_checks u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWr     (cfgWr),
  .cfgEn     (cfgEn),
  .cfgSw     (cfgSw),
  .voltScale (voltScale),
  .regBypass (regBypass),
  .stopEntry (stopEntry),
  .enBit     (enBit),
  .swBit     (swBit),
  .enRdy     (enRdy),
  .swRdy     (swRdy),
  .prepReq   (prepReq),
  .switchReq (switchReq),
  .sysStall  (sysStall)
);

// File: tb/sim_odrive_ctrl.sv
`timescale 1ns/1ps
module sim_odrive_ctrl;

  localparam int TMO = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0, cfgEn = 1'b0, cfgSw = 1'b0;
  logic [1:0] voltScale = 2'b01;
  logic regBypass = 1'b0, stopEntry = 1'b0;
  logic prepAck, switchAck;
  logic enBit, swBit, enRdy, swRdy, prepReq, switchReq, sysStall, timeoutErr;
  logic ackFreeze = 1'b0;
  logic [LAT-1:0] shP, shS;

  int nChk = 0;
  int nErr = 0;
  bit finished = 1'b0;

  typedef struct {
    string      req;
    logic [7:0] mask;
    logic [7:0] exp;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  odrive_ctrl #(.ACK_TIMEOUT(TMO)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEn(cfgEn), .cfgSw(cfgSw),
    .voltScale(voltScale), .regBypass(regBypass), .stopEntry(stopEntry),
    .prepAck(prepAck), .switchAck(switchAck), .enBit(enBit), .swBit(swBit),
    .enRdy(enRdy), .swRdy(swRdy), .prepReq(prepReq), .switchReq(switchReq),
    .sysStall(sysStall), .timeoutErr(timeoutErr)
  );

  // Regulator model: each acknowledge follows its request LAT edges later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shP <= '0;
      shS <= '0;
    end else if (!ackFreeze) begin
      shP <= {shP[LAT-2:0], prepReq};
      shS <= {shS[LAT-2:0], switchReq};
    end
  end
  assign prepAck   = shP[LAT-1];
  assign switchAck = shS[LAT-1];

  // bit order: err stall swReq prepReq swRdy enRdy swBit enBit
  wire [7:0] obs = {timeoutErr, sysStall, switchReq, prepReq, swRdy, enRdy, swBit, enBit};

  // Monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      nChk++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        nErr++;
        $display("FAIL %s: actual %b expected %b (mask %b)", it.req, obs, it.exp, it.mask);
      end
    end
  end

  task automatic expectNext(input string req, input logic [7:0] mask, input logic [7:0] exp);
    expItem_t it;
    it.req = req; it.mask = mask; it.exp = exp;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic en, input logic sw);
    @(negedge clk); #1;
    cfgWr = 1'b1; cfgEn = en; cfgSw = sw;
    @(negedge clk); #1;
    cfgWr = 1'b0; cfgEn = 1'b0; cfgSw = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); #1;
    stopEntry = 1'b1;
    @(negedge clk); #1;
    stopEntry = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nErr++;
      nChk++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    step(4);
    rstN = 1'b1;
    expectNext("R1 reset state", 8'hFF, 8'h00);

    // R4: switch without ready
    wr(1'b0, 1'b1);
    expectNext("R4 switch ignored", 8'hFF, 8'h00);

    // R2: scale 3 and bypass block enable
    voltScale = 2'b11;
    wr(1'b1, 1'b0);
    expectNext("R2 scale3 rejected", 8'hFF, 8'h00);
    voltScale = 2'b01;
    regBypass = 1'b1;
    wr(1'b1, 1'b0);
    expectNext("R2 bypass rejected", 8'hFF, 8'h00);
    regBypass = 1'b0;

    // R2/R3: accepted enable
    wr(1'b1, 1'b0);
    expectNext("R2 enable accepted", 8'hFF, 8'b0001_0001);
    step(5);
    expectNext("R3 enable ready", 8'hFF, 8'b0001_0101);

    // R5: switch to over-drive
    wr(1'b1, 1'b1);
    expectNext("R5 switching stall", 8'hFF, 8'b0111_0111);
    step(5);
    expectNext("R5 over-drive active", 8'hFF, 8'b0011_1111);

    // R6: clear switch only, cycle-exact stall/ready fall
    wr(1'b1, 1'b0);
    expectNext("R6 return stall c1", 8'hFF, 8'b0101_1101);
    expectNext("R6 return stall c2", 8'hFF, 8'b0101_1101);
    expectNext("R6 return stall c3", 8'hFF, 8'b0101_1101);
    expectNext("R6 swRdy and stall fall together", 8'hFF, 8'b0001_0101);

    // R8: disable from enabled-inactive
    wr(1'b0, 1'b0);
    expectNext("R8 disable", 8'hFF, 8'h00);
    step(5);
    wr(1'b1, 1'b0);
    expectNext("R8 re-enable after idle", 8'hFF, 8'b0001_0001);
    step(5);

    // R9: write during switch ignored
    wr(1'b1, 1'b1);
    wr(1'b0, 1'b0);
    expectNext("R9 write in progress ignored", 8'hFF, 8'b0111_0111);
    step(5);
    expectNext("R9 active after ignored write", 8'hFF, 8'b0011_1111);

    // R7: clear both together
    wr(1'b0, 1'b0);
    expectNext("R7 both cleared, returning", 8'hFF, 8'b0101_1100);
    step(4);
    expectNext("R7 back to off", 8'hFF, 8'h00);
    step(5);

    // R10: stop entry from active
    wr(1'b1, 1'b0);
    step(6);
    wr(1'b1, 1'b1);
    step(6);
    pulseStop();
    expectNext("R10 stop clears", 8'hFF, 8'h00);
    wr(1'b1, 1'b0);
    expectNext("R10 enable during drain ignored", 8'hFF, 8'h00);
    step(5);
    wr(1'b1, 1'b0);
    expectNext("R10 enable after stop", 8'hFF, 8'b0001_0001);
    step(5);
    expectNext("R10 ready again", 8'hFF, 8'b0001_0101);

    // R10: bypass from active
    wr(1'b1, 1'b1);
    step(6);
    regBypass = 1'b1;
    step(1);
    expectNext("R10 bypass clears", 8'hFF, 8'h00);
    step(6);
    regBypass = 1'b0;
    step(2);

    // R11: acknowledge timeout
    ackFreeze = 1'b1;
    wr(1'b1, 1'b0);
    step(TMO + 4);
    expectNext("R11 timeout flagged", 8'hFF, 8'b1001_0001);
    ackFreeze = 1'b0;
    step(6);
    expectNext("R11 flag sticky", 8'hFF, 8'b1001_0101);
    wr(1'b0, 1'b0);
    expectNext("R11 flag cleared by write", 8'hFF, 8'h00);

    step(2);
    summary();
    $finish;
  end

endmodule